// File: doc/BRIEF.md
# Streaming Transmit Interface Compliance Monitor

This block watches the source side of a ready/valid transmit stream that uses a ready latency. The sink announces readiness with `tx_ready`. The source may move a beat only when `tx_ready` was high `READY_LAT` cycles earlier. Packets are framed by start and end markers. The monitor never drives the stream. It samples the handshake and the framing signals on every clock edge. From the header fields in the lowest dword lane of the start beat it works out how many beats the packet must span.

Each kind of rule break sets its own sticky flag. The code of the first violation since the last clear or reset is also latched, so a debug path can tell the root cause from the errors that follow it. The window lengths and the ready latency are parameters. One build can check a source that must drop valid within three cycles, and another build a source that must do so within two. The bus width parameter selects 64 or 128 bits, which sets the number of dwords carried in each beat.

Top module: `txstream_tx_checker`

## Requirements
- R1: After reset, `err_flags` and `err_first` are zero. A cycle with `clr` high zeroes both at the next edge. An error that occurs in the same cycle as `clr` is dropped.
- R2: Error code 1 (flag bit 0): `tx_ready` has been low for more than `DROP_WIN` consecutive cycles, counting the cycle in which it fell as the first, and `tx_valid` is still high.
- R3: Error code 2 (flag bit 1): a packet is open, `tx_ready` has been high for exactly `RESUME_WIN`+1 consecutive cycles, and `tx_valid` was low in every one of those cycles.
- R4: Error code 3 (flag bit 2): `tx_valid` is high in any of the first `QUIET_CYC` clock cycles after reset is released.
- R5: Error code 4 (flag bit 3): a packet is open, `tx_ready` was high `READY_LAT` cycles earlier, and `tx_valid` is low.
- R6: Error code 5 (flag bit 4): a valid beat carries the start marker while a packet is already open. That beat starts a new packet.
- R7: Error code 6 (flag bit 5): a valid beat carries the end marker, carries no start marker, and no packet is open.
- R8: Error code 7 (flag bit 6): at the valid end beat, the beats counted from the start beat do not equal the expected count. The expected count is ceil((H + D) / (DATA_W/32)). H is 4 when format bit 0 is set or when the type's upper two bits are 2'b10 (a message); otherwise H is 3. D is 0 when format bit 1 is clear; otherwise D is the 10-bit length, where a length of 0 means 1024.
- R9: Flags stay set until a clear. `err_first` holds the code of the first violation. When several violations occur in one cycle, the lowest code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and first code |
| tx_ready | input | 1 | Sink readiness, before latency |
| tx_valid | input | 1 | Source beat valid |
| tx_sop | input | 1 | Start-of-packet marker |
| tx_eop | input | 1 | End-of-packet marker |
| hdr_fmt | input | 2 | Header format field (data bits 30:29 of lane 0) |
| hdr_type_hi | input | 2 | Upper two type bits (data bits 28:27 of lane 0) |
| hdr_len | input | 10 | Header length in dwords (data bits 9:0 of lane 0) |
| err_flags | output | 7 | Sticky flags; bit k-1 belongs to code k |
| err_first | output | 3 | Code of the first violation, 0 if none |

## Verification
The bench aims at the edges of each window. Valid held for exactly `DROP_WIN` low-ready cycles must pass, and one cycle more must not; an off-by-one counter would flag the legal source or miss the late one. A resume where valid returns in the last allowed cycle must pass, while one that misses it must raise the resume and gap flags together, with the first code showing the resume. This exposes a bad priority order. The header tests use a message with payload, where a 3-dword reading gives a different beat count, and a zero length that must mean 1024 dwords. The quiet test places valid in the last quiet cycle and then in the first cycle after it. A clear that arrives together with a new error must leave everything zero.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

   localparam int NUM_ERR = 7;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_DROP   = 3'd1,
      ERR_RESUME = 3'd2,
      ERR_QUIET  = 3'd3,
      ERR_GAP    = 3'd4,
      ERR_NEST   = 3'd5,
      ERR_ORPHAN = 3'd6,
      ERR_LENGTH = 3'd7
   } err_code_e;

   // Beats a packet must span, from header dword 0 fields.
   function automatic logic [10:0] txmon_beats(input logic [1:0] fmt,
                                               input logic [1:0] kind_hi,
                                               input logic [9:0] len,
                                               input int unsigned lg_dpb);
      logic [11:0] hdr_dw;
      logic [11:0] pay_dw;
      logic [11:0] total;
      hdr_dw = (fmt[0] || kind_hi == 2'b10) ? 12'd4 : 12'd3;
      if (!fmt[1])
         pay_dw = 12'd0;
      else if (len == 10'd0)
         pay_dw = 12'd1024;
      else
         pay_dw = {2'b00, len};
      total = hdr_dw + pay_dw + 12'((1 << lg_dpb) - 1);
      return 11'(total >> lg_dpb);
   endfunction

endpackage

// File: rtl/txmon_handshake.sv
module txmon_handshake #(
   parameter int READY_LAT  = 2,
   parameter int DROP_WIN   = 2,
   parameter int RESUME_WIN = 2,
   parameter int QUIET_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy,
   input  logic vld,
   input  logic pkt_open,
   output logic err_drop,
   output logic err_resume,
   output logic err_quiet,
   output logic err_gap
);

   localparam int WIN_MAX = (DROP_WIN > RESUME_WIN) ? DROP_WIN : RESUME_WIN;
   localparam int CNT_SAT = WIN_MAX + 2;
   localparam int CW      = $clog2(CNT_SAT + 1);
   localparam int QW      = $clog2(QUIET_CYC + 1);

   logic [CW-1:0] lo_cnt_q, hi_cnt_q, lo_now, hi_now;
   logic [QW-1:0] quiet_q;
   logic          seen_q;
   logic          rdy_adj;

   // ready delayed by the latency: the cycle's transfer permission
   generate
      if (READY_LAT == 1) begin : g_lat_one
         logic dly_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) dly_q <= 1'b0;
            else        dly_q <= rdy;
         assign rdy_adj = dly_q;
      end else begin : g_lat_many
         logic [READY_LAT-1:0] dly_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) dly_q <= '0;
            else        dly_q <= {dly_q[READY_LAT-2:0], rdy};
         assign rdy_adj = dly_q[READY_LAT-1];
      end
   endgenerate

   always_comb begin
      lo_now = '0;
      hi_now = '0;
      if (!rdy)
         lo_now = (lo_cnt_q == CW'(CNT_SAT)) ? lo_cnt_q : lo_cnt_q + 1'b1;
      else
         hi_now = (hi_cnt_q == CW'(CNT_SAT)) ? hi_cnt_q : hi_cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt_q <= '0;
         hi_cnt_q <= '0;
         seen_q   <= 1'b0;
         quiet_q  <= '0;
      end else begin
         lo_cnt_q <= lo_now;
         hi_cnt_q <= hi_now;
         seen_q   <= rdy && (seen_q || vld);
         if (quiet_q != QW'(QUIET_CYC))
            quiet_q <= quiet_q + 1'b1;
      end
   end

   assign err_drop   = vld && !rdy && (lo_now > CW'(DROP_WIN));
   assign err_resume = pkt_open && rdy && (hi_now == CW'(RESUME_WIN + 1))
                       && !seen_q && !vld;
   assign err_quiet  = vld && (quiet_q < QW'(QUIET_CYC));
   assign err_gap    = pkt_open && rdy_adj && !vld;

   // R2: a late drop needs ready already low in the previous cycle
   a_r2_drop_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      err_drop |-> !$past(rdy));

   // R3: a missed resume needs ready already high in the previous cycle
   a_r3_resume_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      err_resume |-> $past(rdy));

   // R4: once the quiet period has passed it never returns
   a_r4_quiet_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q == QW'(QUIET_CYC)) |=> (quiet_q == QW'(QUIET_CYC)));

endmodule

// File: rtl/txmon_framing.sv
module txmon_framing #(
   parameter int DATA_W = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld,
   input  logic       sop,
   input  logic       eop,
   input  logic [1:0] fmt,
   input  logic [1:0] kind_hi,
   input  logic [9:0] len,
   output logic       pkt_open,
   output logic       err_nest,
   output logic       err_orphan,
   output logic       err_len
);

   localparam int unsigned LG_DPB = $clog2(DATA_W / 32);

   logic        open_q;
   logic [10:0] beat_q, need_q, beat_now, need_now;

   always_comb begin
      if (sop) begin
         beat_now = 11'd1;
         need_now = txmon_pkg::txmon_beats(fmt, kind_hi, len, LG_DPB);
      end else begin
         beat_now = (beat_q == '1) ? beat_q : beat_q + 1'b1;
         need_now = need_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         beat_q <= '0;
         need_q <= '0;
      end else if (vld) begin
         if (eop)      open_q <= 1'b0;
         else if (sop) open_q <= 1'b1;
         if (sop || open_q) begin
            beat_q <= beat_now;
            need_q <= need_now;
         end
      end
   end

   assign pkt_open   = open_q;
   assign err_nest   = vld && sop && open_q;
   assign err_orphan = vld && eop && !sop && !open_q;
   assign err_len    = vld && eop && (sop || open_q) && (beat_now != need_now);

   // R7: an end beat always leaves no packet open
   a_r7_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && eop) |=> !pkt_open);

   // R6: a start beat without end leaves a packet open
   a_r6_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && sop && !eop) |=> pkt_open);

endmodule

// File: rtl/txmon_errlog.sv
module txmon_errlog #(
   parameter int N = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic [N-1:0]             hit,
   output logic [N-1:0]             flags,
   output logic [$clog2(N+1)-1:0]   first
);

   localparam int CODE_W = $clog2(N + 1);

   logic [N-1:0]      flags_q;
   logic [CODE_W-1:0] first_q, pick;

   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--)
         if (hit[i]) pick = CODE_W'(i + 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         first_q <= '0;
      end else if (clr) begin
         flags_q <= '0;
         first_q <= '0;
      end else begin
         flags_q <= flags_q | hit;
         if (first_q == '0)
            first_q <= pick;
      end
   end

   assign flags = flags_q;
   assign first = first_q;

   // R9: each flag stays set until a clear
   generate
      for (genvar g = 0; g < N; g++) begin : g_sticky
         a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !clr) |=> flags_q[g]);
      end
   endgenerate

   // R9: the first code does not move once captured
   a_r9_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q != '0 && !clr) |=> $stable(first_q));

   // R9: a code is held exactly when some flag is set
   a_r9_code_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q != '0) == (flags_q != '0));

   // R1: a clear empties the log
   a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags_q == '0 && first_q == '0));

endmodule

// File: rtl/txstream_tx_checker.sv
module txstream_tx_checker #(
   parameter int DATA_W     = 128,
   parameter int READY_LAT  = 2,
   parameter int DROP_WIN   = 2,
   parameter int RESUME_WIN = 2,
   parameter int QUIET_CYC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tx_ready,
   input  logic       tx_valid,
   input  logic       tx_sop,
   input  logic       tx_eop,
   input  logic [1:0] hdr_fmt,
   input  logic [1:0] hdr_type_hi,
   input  logic [9:0] hdr_len,
   output logic [6:0] err_flags,
   output logic [2:0] err_first
);

   import txmon_pkg::*;

   initial begin
      assert (DATA_W == 64 || DATA_W == 128) else $error("DATA_W must be 64 or 128");
      assert (READY_LAT >= 1 && READY_LAT <= 4) else $error("READY_LAT out of range");
      assert (DROP_WIN >= 1 && RESUME_WIN >= 1) else $error("windows must be positive");
      assert (QUIET_CYC >= 1) else $error("QUIET_CYC must be positive");
   end

   logic               pkt_open;
   logic               e_drop, e_resume, e_quiet, e_gap;
   logic               e_nest, e_orphan, e_len;
   logic [NUM_ERR-1:0] hits;

   txmon_handshake #(
      .READY_LAT (READY_LAT),
      .DROP_WIN  (DROP_WIN),
      .RESUME_WIN(RESUME_WIN),
      .QUIET_CYC (QUIET_CYC)
   ) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .rdy       (tx_ready),
      .vld       (tx_valid),
      .pkt_open  (pkt_open),
      .err_drop  (e_drop),
      .err_resume(e_resume),
      .err_quiet (e_quiet),
      .err_gap   (e_gap)
   );

   txmon_framing #(.DATA_W(DATA_W)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld       (tx_valid),
      .sop       (tx_sop),
      .eop       (tx_eop),
      .fmt       (hdr_fmt),
      .kind_hi   (hdr_type_hi),
      .len       (hdr_len),
      .pkt_open  (pkt_open),
      .err_nest  (e_nest),
      .err_orphan(e_orphan),
      .err_len   (e_len)
   );

   assign hits = {e_len, e_orphan, e_nest, e_gap, e_quiet, e_resume, e_drop};

   txmon_errlog #(.N(NUM_ERR)) u_log (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .hit  (hits),
      .flags(err_flags),
      .first(err_first)
   );

endmodule

// File: tb/txstream_tx_checker_test.sv
module txstream_tx_checker_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       rdy = 1'b0, vld = 1'b0, sop = 1'b0, eop = 1'b0;
   logic [1:0] hf = 2'b00, ht = 2'b00;
   logic [9:0] hl = 10'd0;
   logic [6:0] flags;
   logic [2:0] first;
   int         n_vec = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   txstream_tx_checker uut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .tx_ready(rdy), .tx_valid(vld), .tx_sop(sop), .tx_eop(eop),
      .hdr_fmt(hf), .hdr_type_hi(ht), .hdr_len(hl),
      .err_flags(flags), .err_first(first)
   );

   task automatic cyc(input logic c, input logic r, input logic v,
                      input logic s, input logic e);
      @(negedge clk);
      clr = c; rdy = r; vld = v; sop = s; eop = e;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [6:0] ef, input logic [2:0] ec);
      n_vec++;
      if (flags !== ef || first !== ec) begin
         n_bad++;
         $display("FAIL %s: flags=%b first=%0d expected flags=%b first=%0d",
                  req, flags, first, ef, ec);
      end
   endtask

   task automatic hdr(input logic [1:0] f, input logic [1:0] t, input logic [9:0] l);
      hf = f; ht = t; hl = l;
   endtask

   // Reset ends at a falling edge; the next rising edge is quiet cycle 0.
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; clr = 1'b0; rdy = 1'b1; vld = 1'b0; sop = 1'b0; eop = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic settle();
      do_reset();
      cyc(0, 1, 0, 0, 0);
      cyc(0, 1, 0, 0, 0);
   endtask

   task automatic t_reset_state();
      settle();
      chk("R1 reset state", 7'b0, 3'd0);
   endtask

   task automatic t_good_packets();
      settle();
      hdr(2'b10, 2'b00, 10'd5);            // 3+5 dwords -> 2 beats
      cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 0, 1);
      hdr(2'b11, 2'b00, 10'd1);            // 4+1 -> 2 beats
      cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 0, 1);
      hdr(2'b00, 2'b00, 10'd4);            // read, 3 dwords -> 1 beat
      cyc(0, 1, 1, 1, 1);
      hdr(2'b10, 2'b10, 10'd1);            // message: 4+1 -> 2 beats
      cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 0, 1);
      chk("R8 legal packets", 7'b0, 3'd0);
      hdr(2'b10, 2'b10, 10'd1);            // message sent as one beat
      cyc(0, 1, 1, 1, 1);
      chk("R8 message four-dword header", 7'b1000000, 3'd7);
   endtask

   task automatic t_len_1024();
      settle();
      hdr(2'b10, 2'b00, 10'd0);            // 3+1024 -> 257 beats
      cyc(0, 1, 1, 1, 0);
      for (int i = 0; i < 255; i++) cyc(0, 1, 1, 0, 0);
      cyc(0, 1, 1, 0, 1);
      chk("R8 zero length is 1024", 7'b0, 3'd0);
      cyc(0, 1, 1, 1, 0);
      for (int i = 0; i < 254; i++) cyc(0, 1, 1, 0, 0);
      cyc(0, 1, 1, 0, 1);
      chk("R8 one beat short", 7'b1000000, 3'd7);
   endtask

   task automatic t_drop();
      settle();
      cyc(0, 0, 1, 0, 0);
      cyc(0, 0, 1, 0, 0);
      chk("R2 valid held for the whole window", 7'b0, 3'd0);
      cyc(0, 0, 1, 0, 0);
      chk("R2 valid held one cycle too long", 7'b0000001, 3'd1);
   endtask

   task automatic t_resume(input bit late);
      settle();
      hdr(2'b10, 2'b00, 10'd17);           // 20 dwords -> 5 beats
      cyc(0, 1, 1, 1, 0);                  // beat 1
      cyc(0, 0, 1, 0, 0);                  // beat 2, ready falls
      cyc(0, 0, 1, 0, 0);                  // beat 3
      cyc(0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0);                  // ready back
      cyc(0, 1, 0, 0, 0);
      if (!late) begin
         cyc(0, 1, 1, 0, 0);               // beat 4 in last allowed cycle
         cyc(0, 1, 1, 0, 1);
         chk("R3 resume at window edge", 7'b0, 3'd0);
      end else begin
         cyc(0, 1, 0, 0, 0);
         chk("R3 missed resume, R9 lowest code first", 7'b0001010, 3'd2);
         cyc(0, 1, 1, 0, 0);
         cyc(0, 1, 1, 0, 1);
         chk("R9 flags kept after packet ends", 7'b0001010, 3'd2);
      end
   endtask

   task automatic t_quiet();
      do_reset();
      cyc(0, 1, 1, 0, 0);                  // quiet cycle 1
      chk("R4 beat inside quiet period", 7'b0000100, 3'd3);
      do_reset();
      cyc(0, 1, 0, 0, 0);
      cyc(0, 1, 1, 0, 0);                  // cycle 2, after quiet
      chk("R4 beat after quiet period", 7'b0, 3'd0);
   endtask

   task automatic t_gap();
      settle();
      hdr(2'b10, 2'b00, 10'd9);            // 12 dwords -> 3 beats
      cyc(0, 1, 1, 1, 0);
      cyc(0, 1, 0, 0, 0);
      chk("R5 idle beat while allowed", 7'b0001000, 3'd4);
      cyc(0, 1, 1, 0, 0);
      cyc(0, 1, 1, 0, 1);
      chk("R5 gap does not count as beat", 7'b0001000, 3'd4);
   endtask

   task automatic t_nest();
      settle();
      hdr(2'b10, 2'b00, 10'd5);
      cyc(0, 1, 1, 1, 0);
      cyc(0, 1, 1, 1, 0);
      cyc(0, 1, 1, 0, 1);
      chk("R6 start inside open packet", 7'b0010000, 3'd5);
   endtask

   task automatic t_orphan_and_clear();
      settle();
      cyc(0, 1, 1, 0, 1);
      chk("R7 end with no packet", 7'b0100000, 3'd6);
      hdr(2'b10, 2'b00, 10'd5);
      cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 0, 0); cyc(0, 1, 1, 0, 1);
      chk("R9 first code kept", 7'b1100000, 3'd6);
      cyc(1, 1, 0, 0, 0);
      chk("R1 clear", 7'b0, 3'd0);
      cyc(1, 1, 1, 0, 1);
      chk("R1 clear wins over new error", 7'b0, 3'd0);
      cyc(0, 1, 0, 0, 0);
      chk("R1 nothing left after clear", 7'b0, 3'd0);
   endtask

   initial begin
      t_reset_state();
      t_good_packets();
      t_len_1024();
      t_drop();
      t_resume(1'b0);
      t_resume(1'b1);
      t_quiet();
      t_gap();
      t_nest();
      t_orphan_and_clear();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run still busy, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule